// File: doc/BRIEF.md
# Serial Reclocker Lock Detector

This block sits behind a clock-and-data recovery loop. It receives the reclocked serial stream one bit per recovered-clock cycle, with a strobe that marks the cycles that carry a real bit. From that stream alone it decides whether the loop is genuinely locked. Two conditions must hold. First, the stream must keep toggling, because a dead or stuck input gives no phase information. Second, the loop must be running at the true bit rate and not at a sub-harmonic. When a loop runs at a sub-harmonic, every bit cell is sampled twice, so an isolated one or zero can never appear.

A third condition covers gaps in the strobe. A short gap is tolerated, so a quick source switch at the same rate does not disturb the downstream logic. A long gap is treated as loss of data. The lock flag is the AND of the three conditions. The serial output follows the input only while lock is high. Otherwise the output is frozen at the last level that was passed, so the next stage never sees noise as data. All window lengths are parameters counted in clock cycles or valid bits.

Top module: `serial_lock_detect`

## Requirements
- R1: While reset is applied, lock_o=0, data_o=0, trans_ok_o=0 and fund_ok_o=0. strobe_ok_o=1 because its gap counter starts at zero.
- R2: A transition is a valid bit that differs from the previous valid bit. The first valid bit after reset is never a transition. trans_ok_o is 1 from the clock after any transition.
- R3: trans_ok_o falls on the clock of the RUN_LIMIT-th consecutive valid bit that follows the last transition without being a transition itself.
- R4: fund_ok_o is 1 from the clock after any valid bit that completes the pattern 1,0,1 or 0,1,0 over the last three valid bits. It falls on the clock of the SINGLE_WINDOW-th valid bit after the last such pattern.
- R5: A stream made only of runs of two or more equal bits, such as 0,0,1,1,0,0,..., never raises fund_ok_o, so lock_o stays 0.
- R6: strobe_ok_o falls after GAP_LIMIT consecutive clocks with bit_vld=0. It returns to 1 on the clock after the next valid bit. Clocks with bit_vld=0 advance neither the transition window nor the pattern window, and they do not change the bit history.
- R7: A strobe gap shorter than GAP_LIMIT clocks leaves lock_o high and data_o unchanged.
- R8: lock_o equals trans_ok_o AND fund_ok_o AND strobe_ok_o in the same cycle.
- R9: While lock_o is 0, data_o holds the last bit that was passed, which is 0 after reset. Passing resumes with the first valid bit sampled while lock_o is 1.
- R10: A valid bit sampled while lock_o is 1 appears on data_o one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Reclocked serial bit |
| bit_vld | input | 1 | High when bit_in carries a bit this cycle |
| lock_o | output | 1 | Receiver judged locked |
| data_o | output | 1 | Serial data, frozen while unlocked |
| trans_ok_o | output | 1 | Transitions arriving within the run window |
| fund_ok_o | output | 1 | Single-bit runs seen within the pattern window |
| strobe_ok_o | output | 1 | Strobe gap shorter than the gap limit |

## Verification
Each internal fault has a distinct signature at the ports:
- A run counter that advances during strobe gaps drops trans_ok_o early, in the first long run that straddles a short gap.
- A history register that shifts in invalid bits fabricates or hides a single-bit pattern, which shows on fund_ok_o within one window.
- A wrong pass condition on the output latch shows on data_o as a changed level on the clock right after lock falls.
- A sub-harmonic stream that is wrongly accepted shows as lock_o rising within three valid bits.

The directed cases stop exactly one bit short of each limit and then exactly at it. This exposes off-by-one errors in the counters.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // True while a count taken since the last qualifying event is still inside its window.
  function automatic logic window_open(input int unsigned cnt, input int unsigned limit);
    return cnt < limit;
  endfunction

  // A three-bit window holding an isolated bit: only possible at the true bit rate.
  function automatic logic is_single_run(input logic [2:0] w);
    return (w == 3'b101) || (w == 3'b010);
  endfunction

endpackage

// File: rtl/lockdet_hist.sv
module lockdet_hist (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic trans_evt,
  output logic single_evt
);
  import lockdet_pkg::*;

  logic [1:0] hist_q;
  logic [1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b00;
      fill_q <= 2'd0;
    end else if (bit_vld) begin
      hist_q <= {hist_q[0], bit_in};
      if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
    end
  end

  assign trans_evt  = bit_vld && (fill_q != 2'd0) && (bit_in != hist_q[0]);
  assign single_evt = bit_vld && (fill_q == 2'd2) && is_single_run({hist_q, bit_in});
endmodule

// File: rtl/lockdet_window.sv
module lockdet_window #(
  parameter int unsigned LIMIT      = 16,
  parameter bit          NEED_EVENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic open_o
);
  import lockdet_pkg::*;

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (restart)                          cnt_q <= '0;
    else if (advance && cnt_q != CW'(LIMIT))   cnt_q <= cnt_q + 1'b1;
  end

  assign below = window_open(32'(cnt_q), LIMIT);

  generate
    if (NEED_EVENT) begin : g_seen
      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_q <= 1'b0;
        else if (restart) seen_q <= 1'b1;
      end
      assign open_o = seen_q & below;
    end else begin : g_free
      assign open_o = below;
    end
  endgenerate
endmodule

// File: rtl/lockdet_mute.sv
module lockdet_mute (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic bit_vld,
  input  logic bit_in,
  output logic data_o
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  out_q <= 1'b0;
    else if (lock_i && bit_vld)  out_q <= bit_in;
  end

  assign data_o = out_q;
endmodule

// File: rtl/serial_lock_detect.sv
module serial_lock_detect #(
  parameter int unsigned RUN_LIMIT     = 16,
  parameter int unsigned GAP_LIMIT     = 8,
  parameter int unsigned SINGLE_WINDOW = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic lock_o,
  output logic data_o,
  output logic trans_ok_o,
  output logic fund_ok_o,
  output logic strobe_ok_o
);
  logic trans_evt;
  logic single_evt;
  logic gap_cycle;

  assign gap_cycle = !bit_vld;

  lockdet_hist u_hist (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .trans_evt(trans_evt), .single_evt(single_evt)
  );

  lockdet_window #(.LIMIT(RUN_LIMIT), .NEED_EVENT(1'b1)) u_run_win (
    .clk(clk), .rst_n(rst_n), .restart(trans_evt), .advance(bit_vld), .open_o(trans_ok_o)
  );

  lockdet_window #(.LIMIT(SINGLE_WINDOW), .NEED_EVENT(1'b1)) u_pat_win (
    .clk(clk), .rst_n(rst_n), .restart(single_evt), .advance(bit_vld), .open_o(fund_ok_o)
  );

  lockdet_window #(.LIMIT(GAP_LIMIT), .NEED_EVENT(1'b0)) u_gap_win (
    .clk(clk), .rst_n(rst_n), .restart(bit_vld), .advance(gap_cycle), .open_o(strobe_ok_o)
  );

  assign lock_o = trans_ok_o & fund_ok_o & strobe_ok_o;

  lockdet_mute u_mute (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_o), .bit_vld(bit_vld),
    .bit_in(bit_in), .data_o(data_o)
  );
endmodule

// File: rtl/serial_lock_detect_chk.sv
module serial_lock_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_in,
  input logic bit_vld,
  input logic lock_o,
  input logic data_o,
  input logic trans_ok_o,
  input logic fund_ok_o,
  input logic strobe_ok_o,
  input logic trans_evt,
  input logic single_evt
);
  a_r2_trans_opens: assert property (@(posedge clk) disable iff (!rst_n)
    trans_evt |=> trans_ok_o);

  a_r4_single_opens: assert property (@(posedge clk) disable iff (!rst_n)
    single_evt |=> fund_ok_o);

  a_r5_fund_needs_single: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fund_ok_o) |-> $past(single_evt));

  a_r6_strobe_restores: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> strobe_ok_o);

  a_r9_mute_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |=> $stable(data_o));

  a_r10_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && bit_vld) |=> (data_o == $past(bit_in)));
endmodule

bind serial_lock_detect serial_lock_detect_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
  .lock_o(lock_o), .data_o(data_o), .trans_ok_o(trans_ok_o),
  .fund_ok_o(fund_ok_o), .strobe_ok_o(strobe_ok_o),
  .trans_evt(trans_evt), .single_evt(single_evt)
);

// File: tb/serial_lock_detect_tb_top.sv
module serial_lock_detect_tb_top;
  localparam int unsigned RUN_LIMIT     = 16;
  localparam int unsigned GAP_LIMIT     = 8;
  localparam int unsigned SINGLE_WINDOW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic lock_o, data_o, trans_ok_o, fund_ok_o, strobe_ok_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  serial_lock_detect #(.RUN_LIMIT(RUN_LIMIT), .GAP_LIMIT(GAP_LIMIT),
                       .SINGLE_WINDOW(SINGLE_WINDOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .lock_o(lock_o), .data_o(data_o), .trans_ok_o(trans_ok_o),
    .fund_ok_o(fund_ok_o), .strobe_ok_o(strobe_ok_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; sample just after the next rising edge.
  task automatic step(input logic v, input logic b);
    @(negedge clk);
    bit_vld = v;
    bit_in  = b;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_vld = 1'b0;
    bit_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Sends 0,1,0: transition on bit 2, isolated bit on bit 3.
  task automatic acquire();
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "lock_o",      lock_o,      1'b0);
    check("R1", "data_o",      data_o,      1'b0);
    check("R1", "trans_ok_o",  trans_ok_o,  1'b0);
    check("R1", "fund_ok_o",   fund_ok_o,   1'b0);
    check("R1", "strobe_ok_o", strobe_ok_o, 1'b1);
    release_reset();
  endtask

  task automatic t_acquire_pass();
    do_reset();
    release_reset();
    step(1'b1, 1'b0);
    check("R2", "trans_ok after first bit", trans_ok_o, 1'b0);
    step(1'b1, 1'b1);
    check("R2", "trans_ok after transition", trans_ok_o, 1'b1);
    check("R8", "lock without pattern", lock_o, 1'b0);
    step(1'b1, 1'b0);
    check("R4", "fund_ok after 010", fund_ok_o, 1'b1);
    check("R8", "lock with all ok", lock_o, 1'b1);
    check("R9", "data_o still muted", data_o, 1'b0);
    step(1'b1, 1'b1);
    check("R10", "data_o passes 1", data_o, 1'b1);
    step(1'b1, 1'b0);
    check("R10", "data_o passes 0", data_o, 1'b0);
  endtask

  task automatic t_run_timeout();
    do_reset();
    release_reset();
    acquire();
    step(1'b1, 1'b1);
    for (int i = 0; i < RUN_LIMIT - 1; i++) step(1'b1, 1'b1);
    check("R3", "trans_ok one short of limit", trans_ok_o, 1'b1);
    check("R10", "data_o in long run", data_o, 1'b1);
    step(1'b1, 1'b1);
    check("R3", "trans_ok at limit", trans_ok_o, 1'b0);
    check("R8", "lock after run timeout", lock_o, 1'b0);
    step(1'b1, 1'b0);
    check("R9", "data_o held after lock loss", data_o, 1'b1);
    check("R2", "lock back after transition", lock_o, 1'b1);
    step(1'b1, 1'b0);
    check("R9", "pass resumes", data_o, 1'b0);
  endtask

  task automatic t_single_timeout();
    do_reset();
    release_reset();
    acquire();
    step(1'b1, 1'b1);
    for (int k = 0; k < SINGLE_WINDOW; k++) begin
      logic b;
      b = (k == 0) ? 1'b1 : ((((k - 1) / 2) % 2) == 0 ? 1'b0 : 1'b1);
      step(1'b1, b);
      if (k == SINGLE_WINDOW - 2) check("R4", "fund_ok one short of window", fund_ok_o, 1'b1);
    end
    check("R4", "fund_ok at window end", fund_ok_o, 1'b0);
    check("R4", "trans_ok with pairs", trans_ok_o, 1'b1);
    check("R8", "lock after pattern timeout", lock_o, 1'b0);
  endtask

  task automatic t_harmonic();
    logic saw_fund, saw_lock, saw_data, trans_low;
    saw_fund = 1'b0; saw_lock = 1'b0; saw_data = 1'b0; trans_low = 1'b0;
    do_reset();
    release_reset();
    for (int k = 0; k < 60; k++) begin
      step(1'b1, ((k / 2) % 2) == 1);
      saw_fund |= fund_ok_o;
      saw_lock |= lock_o;
      saw_data |= data_o;
      if (k >= 2 && !trans_ok_o) trans_low = 1'b1;
    end
    check("R5", "fund_ok ever high on doubled stream", saw_fund, 1'b0);
    check("R5", "lock ever high on doubled stream", saw_lock, 1'b0);
    check("R5", "data_o ever left mute level", saw_data, 1'b0);
    check("R5", "trans_ok dropped on doubled stream", trans_low, 1'b0);
  endtask

  task automatic t_short_gap();
    do_reset();
    release_reset();
    acquire();
    step(1'b1, 1'b1);
    for (int i = 0; i < RUN_LIMIT - 1; i++) step(1'b1, 1'b1);
    for (int i = 0; i < GAP_LIMIT - 1; i++) step(1'b0, 1'b0);
    check("R7", "strobe_ok over short gap", strobe_ok_o, 1'b1);
    check("R7", "lock over short gap", lock_o, 1'b1);
    check("R7", "data_o over short gap", data_o, 1'b1);
    check("R6", "run window frozen in gap", trans_ok_o, 1'b1);
    step(1'b1, 1'b1);
    check("R3", "trans_ok at limit after gap", trans_ok_o, 1'b0);
  endtask

  task automatic t_long_gap();
    do_reset();
    release_reset();
    acquire();
    step(1'b1, 1'b1);
    for (int i = 0; i < GAP_LIMIT - 1; i++) step(1'b0, 1'b0);
    check("R6", "strobe_ok one short of gap limit", strobe_ok_o, 1'b1);
    step(1'b0, 1'b0);
    check("R6", "strobe_ok at gap limit", strobe_ok_o, 1'b0);
    check("R8", "lock at gap limit", lock_o, 1'b0);
    check("R9", "data_o held in long gap", data_o, 1'b1);
    step(1'b1, 1'b0);
    check("R6", "strobe_ok after valid bit", strobe_ok_o, 1'b1);
    check("R8", "lock back after gap", lock_o, 1'b1);
    check("R9", "data_o still held", data_o, 1'b1);
    step(1'b1, 1'b0);
    check("R10", "data_o passes after gap", data_o, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire_pass();
    t_run_timeout();
    t_single_timeout();
    t_harmonic();
    t_short_gap();
    t_long_gap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule